// File: doc/BRIEF.md
# Two-Wire Debug Entry Sequencer

This block drives the pin sequence that moves a target's test logic into two-wire debug mode. A one-cycle request pulse starts it. The block then takes over the debug clock line and the debug data line, sets both to output, and steps through a fixed series of timed phases. Every hold time is counted in system clock cycles, and the cycle counts are derived from a clock-frequency parameter.

The sequence runs as follows:

- The clock line is held low for a reset hold and then a short gap.
- The clock line goes high for the activation hold and then a pre-latch hold.
- The clock line drops for one short low pulse, which latches the mode request.
- The clock line goes high again for a post-latch hold and a final settle time.

The data line is driven high the whole time. When the settle time has expired, the block raises a done flag so that the scan logic can take over the lines. The interface uses plain control and status pins and has no data stream, so there is no valid/ready handshake and no back-pressure. The request is a level that is sampled on each clock edge.

Top module: `dbg_entry_seq`

## Requirements
- R1: In reset, and in idle after reset, both output enables are 0, both line levels are 0 and `entry_done` is 0.
- R2: A request sampled high in idle makes the block drive both lines from the next cycle. The clock line is low and the data line is high.
- R3: The clock line stays low for ceil(CLK_HZ·RESET_US/1e6) + ceil(CLK_HZ·GAP_US/1e6) cycles. This is the 4 ms reset hold followed by the 1 µs gap.
- R4: The clock line then stays high for ceil(CLK_HZ·ACT_US/1e6) + ceil(CLK_HZ·HOLD_US/1e6) cycles. This is the 20 ms activation hold followed by the 60 µs pre-latch hold.
- R5: The clock line is then low for ceil(CLK_HZ·LATCH_US/1e6) cycles. This is the 1 µs latch pulse.
- R6: The clock line then stays high for ceil(CLK_HZ·POST_US/1e6) + ceil(CLK_HZ·SETTLE_US/1e6) cycles with `entry_done` low. This is the 60 µs post-latch hold followed by the 5 ms settle time. `entry_done` rises in the cycle after that.
- R7: Whenever the lines are driven, the data line is driven high.
- R8: Once `entry_done` is high, it stays high with the clock line driven high until reset or a new request.
- R9: A request that arrives while the sequence is running is ignored, and every phase keeps its length.
- R10: A request sampled while `entry_done` is high restarts the sequence. From the next cycle `entry_done` is low and the clock line is driven low.
- R11: Every interval is rounded up to whole cycles, with a minimum of one cycle, so no interval is ever shorter than its stated length.
- R12: A reset in the middle of the sequence releases both lines and clears `entry_done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_req | input | 1 | Start request, sampled every cycle |
| dbg_clk_o | output | 1 | Debug clock line level |
| dbg_clk_oe | output | 1 | Debug clock line output enable |
| dbg_dat_o | output | 1 | Debug data line level |
| dbg_dat_oe | output | 1 | Debug data line output enable |
| entry_done | output | 1 | Sequence complete, scan logic may start |

## Verification
The bench runs at a clock frequency where 1 µs comes to 1.5 cycles. A design that truncated instead of rounding up would make the latch pulse and the gap one cycle long each, and would shift the merged low-run count.

Every low run and high run of the clock line is measured exactly. An off-by-one in the phase counter would show up as a run one cycle too long or too short.

Requests are injected in every phase while the sequence runs. A design that restarted on them would show a truncated run or a second low pulse.

The bench also restarts the sequence from the done state and resets it in the middle of a run. A design that kept driving the pins after reset, or kept the done flag high after a restart, would be caught.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  typedef enum logic [3:0] {
    PH_IDLE   = 4'd0,
    PH_RST    = 4'd1,
    PH_GAP    = 4'd2,
    PH_ACT    = 4'd3,
    PH_HOLD   = 4'd4,
    PH_LATCH  = 4'd5,
    PH_POST   = 4'd6,
    PH_SETTLE = 4'd7,
    PH_DONE   = 4'd8
  } phase_e;

  // Cycles for an interval in microseconds, rounded up, never below one.
  function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                   longint unsigned us);
    longint unsigned r;
    r = (hz * us + 64'd999_999) / 64'd1_000_000;
    if (r == 0) r = 1;
    return r;
  endfunction

endpackage

// File: rtl/dbg_entry_timer.sv
module dbg_entry_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_entry_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   expired,
  output phase_e phase,
  output phase_e nxt,
  output logic   load
);
  phase_e phase_q;

  always_comb begin
    nxt  = phase_q;
    load = 1'b0;
    unique case (phase_q)
      PH_IDLE, PH_DONE: if (req) begin nxt = PH_RST; load = 1'b1; end
      PH_RST:    if (expired) begin nxt = PH_GAP;    load = 1'b1; end
      PH_GAP:    if (expired) begin nxt = PH_ACT;    load = 1'b1; end
      PH_ACT:    if (expired) begin nxt = PH_HOLD;   load = 1'b1; end
      PH_HOLD:   if (expired) begin nxt = PH_LATCH;  load = 1'b1; end
      PH_LATCH:  if (expired) begin nxt = PH_POST;   load = 1'b1; end
      PH_POST:   if (expired) begin nxt = PH_SETTLE; load = 1'b1; end
      PH_SETTLE: if (expired) nxt = PH_DONE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= nxt;
  end

  assign phase = phase_q;
endmodule

// File: rtl/dbg_entry_pins.sv
module dbg_entry_pins
  import dbg_entry_pkg::*;
(
  input  phase_e phase,
  output logic   clk_o,
  output logic   clk_oe,
  output logic   dat_o,
  output logic   dat_oe,
  output logic   done
);
  always_comb begin
    clk_oe = (phase != PH_IDLE);
    dat_oe = clk_oe;
    dat_o  = clk_oe;
    done   = (phase == PH_DONE);
    unique case (phase)
      PH_ACT, PH_HOLD, PH_POST, PH_SETTLE, PH_DONE: clk_o = 1'b1;
      default:                                      clk_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq
  import dbg_entry_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter longint unsigned RESET_US  = 4000,
  parameter longint unsigned GAP_US    = 1,
  parameter longint unsigned ACT_US    = 20000,
  parameter longint unsigned HOLD_US   = 60,
  parameter longint unsigned LATCH_US  = 1,
  parameter longint unsigned POST_US   = 60,
  parameter longint unsigned SETTLE_US = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic entry_req,
  output logic dbg_clk_o,
  output logic dbg_clk_oe,
  output logic dbg_dat_o,
  output logic dbg_dat_oe,
  output logic entry_done
);
  localparam longint unsigned N_RST    = us_to_cycles(CLK_HZ, RESET_US);
  localparam longint unsigned N_GAP    = us_to_cycles(CLK_HZ, GAP_US);
  localparam longint unsigned N_ACT    = us_to_cycles(CLK_HZ, ACT_US);
  localparam longint unsigned N_HOLD   = us_to_cycles(CLK_HZ, HOLD_US);
  localparam longint unsigned N_LATCH  = us_to_cycles(CLK_HZ, LATCH_US);
  localparam longint unsigned N_POST   = us_to_cycles(CLK_HZ, POST_US);
  localparam longint unsigned N_SETTLE = us_to_cycles(CLK_HZ, SETTLE_US);

  localparam longint unsigned M0 = (N_RST  > N_GAP)   ? N_RST  : N_GAP;
  localparam longint unsigned M1 = (N_ACT  > N_HOLD)  ? N_ACT  : N_HOLD;
  localparam longint unsigned M2 = (N_LATCH > N_POST) ? N_LATCH : N_POST;
  localparam longint unsigned M3 = (M0 > M1) ? M0 : M1;
  localparam longint unsigned M4 = (M2 > N_SETTLE) ? M2 : N_SETTLE;
  localparam longint unsigned N_MAX = (M3 > M4) ? M3 : M4;
  localparam int CW = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  phase_e        phase, nxt;
  logic          load, expired;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (nxt)
      PH_RST:    load_val = CW'(N_RST - 1);
      PH_GAP:    load_val = CW'(N_GAP - 1);
      PH_ACT:    load_val = CW'(N_ACT - 1);
      PH_HOLD:   load_val = CW'(N_HOLD - 1);
      PH_LATCH:  load_val = CW'(N_LATCH - 1);
      PH_POST:   load_val = CW'(N_POST - 1);
      PH_SETTLE: load_val = CW'(N_SETTLE - 1);
      default:   load_val = '0;
    endcase
  end

  dbg_entry_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (entry_req),
    .expired (expired),
    .phase   (phase),
    .nxt     (nxt),
    .load    (load)
  );

  dbg_entry_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  dbg_entry_pins u_pins (
    .phase  (phase),
    .clk_o  (dbg_clk_o),
    .clk_oe (dbg_clk_oe),
    .dat_o  (dbg_dat_o),
    .dat_oe (dbg_dat_oe),
    .done   (entry_done)
  );
endmodule

// File: rtl/dbg_entry_seq_chk.sv
module dbg_entry_seq_chk (
  input logic clk,
  input logic rst,
  input logic entry_req,
  input logic dbg_clk_o,
  input logic dbg_clk_oe,
  input logic dbg_dat_o,
  input logic dbg_dat_oe,
  input logic entry_done
);
  // R7: data line high whenever driven
  a_r7_data_high: assert property (@(posedge clk) disable iff (rst)
    dbg_dat_oe |-> dbg_dat_o);

  // R7: both lines enabled together
  a_r7_oe_pair: assert property (@(posedge clk) disable iff (rst)
    dbg_clk_oe == dbg_dat_oe);

  // R2: idle request starts the sequence with clock low
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (!dbg_clk_oe && entry_req) |=> (dbg_clk_oe && !dbg_clk_o && !entry_done));

  // R2: drive only begins on a request
  a_r2_rise_on_req: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_clk_oe) |-> $past(entry_req));

  // R8: done implies clock driven high
  a_r8_done_driven: assert property (@(posedge clk) disable iff (rst)
    entry_done |-> (dbg_clk_oe && dbg_clk_o));

  // R8: done only falls on request or reset
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(entry_done) |-> ($past(entry_req) || $past(rst)));

  // R6: done rises only after the clock line was already high
  a_r6_done_after_high: assert property (@(posedge clk) disable iff (rst)
    $rose(entry_done) |-> $past(dbg_clk_o));
endmodule

bind dbg_entry_seq dbg_entry_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .entry_req  (entry_req),
  .dbg_clk_o  (dbg_clk_o),
  .dbg_clk_oe (dbg_clk_oe),
  .dbg_dat_o  (dbg_dat_o),
  .dbg_dat_oe (dbg_dat_oe),
  .entry_done (entry_done)
);

// File: tb/dbg_entry_seq_bench.sv
`timescale 1ns/1ps
module dbg_entry_seq_bench;
  localparam longint unsigned HZ = 1_500_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entry_req = 1'b0;
  logic dbg_clk_o, dbg_clk_oe, dbg_dat_o, dbg_dat_oe, entry_done;

  int checks = 0;
  int errors = 0;
  bit data_bad;

  always #5 clk = ~clk;

  dbg_entry_seq #(.CLK_HZ(HZ)) u_dbg_entry_seq (
    .clk(clk), .rst(rst), .entry_req(entry_req),
    .dbg_clk_o(dbg_clk_o), .dbg_clk_oe(dbg_clk_oe),
    .dbg_dat_o(dbg_dat_o), .dbg_dat_oe(dbg_dat_oe),
    .entry_done(entry_done)
  );

  function automatic int cyc(longint unsigned us);
    longint unsigned r;
    r = (HZ * us + 999_999) / 1_000_000;
    if (r == 0) r = 1;
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count samples while the clock line is driven at lvl and done is low.
  // A request pulse is injected when the count reaches poke (negative: none).
  task automatic run_len(input logic lvl, input int poke, output int n);
    n = 0;
    while (dbg_clk_oe && dbg_clk_o == lvl && !entry_done && n < 100000) begin
      if (!dbg_dat_oe || !dbg_dat_o) data_bad = 1'b1;
      n++;
      entry_req = (n == poke);
      @(negedge clk);
    end
    entry_req = 1'b0;
  endtask

  task automatic pulse_req();
    entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(!dbg_clk_oe && !dbg_dat_oe && !entry_done && !dbg_clk_o && !dbg_dat_o,
        "R1 reset", {dbg_clk_oe, dbg_dat_oe, entry_done, dbg_clk_o, dbg_dat_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dbg_clk_oe && !dbg_dat_oe && !entry_done, "R1 idle",
        {dbg_clk_oe, dbg_dat_oe, entry_done}, 0);
  endtask

  task automatic t_sequence(input int poke, input string tag);
    int n;
    data_bad = 1'b0;
    pulse_req();
    chk(dbg_clk_oe && dbg_dat_oe && !dbg_clk_o && dbg_dat_o && !entry_done,
        {tag, " R2 start levels"},
        {dbg_clk_oe, dbg_dat_oe, dbg_clk_o, dbg_dat_o, entry_done}, 5'b11010);
    run_len(1'b0, poke, n);
    chk(n == cyc(4000) + cyc(1), {tag, " R3 reset+gap low"}, n, cyc(4000) + cyc(1));
    run_len(1'b1, poke, n);
    chk(n == cyc(20000) + cyc(60), {tag, " R4 activate high"}, n, cyc(20000) + cyc(60));
    run_len(1'b0, poke, n);
    chk(n == cyc(1), {tag, " R5 latch low"}, n, cyc(1));
    chk(n * 1_000_000 >= int'(HZ), {tag, " R11 latch not short"}, n, 2);
    run_len(1'b1, poke, n);
    chk(n == cyc(60) + cyc(5000), {tag, " R6 post+settle high"}, n, cyc(60) + cyc(5000));
    chk(entry_done && dbg_clk_oe && dbg_clk_o, {tag, " R6 done raised"},
        {entry_done, dbg_clk_oe, dbg_clk_o}, 3'b111);
    chk(!data_bad, {tag, " R7 data high"}, data_bad, 0);
    repeat (5) @(negedge clk);
    chk(entry_done && dbg_clk_o && dbg_dat_o && dbg_dat_oe, {tag, " R8 done held"},
        {entry_done, dbg_clk_o, dbg_dat_o, dbg_dat_oe}, 4'b1111);
  endtask

  task automatic t_restart_and_abort();
    int n;
    pulse_req();
    chk(!entry_done && dbg_clk_oe && !dbg_clk_o, "R10 restart from done",
        {entry_done, dbg_clk_oe, dbg_clk_o}, 3'b010);
    run_len(1'b0, -1, n);
    chk(n == cyc(4000) + cyc(1), "R10 restart low run", n, cyc(4000) + cyc(1));
    repeat (100) @(negedge clk);
    chk(dbg_clk_oe && dbg_clk_o, "R12 mid-run driving", {dbg_clk_oe, dbg_clk_o}, 3);
    rst = 1'b1;
    @(negedge clk);
    chk(!dbg_clk_oe && !dbg_dat_oe && !entry_done, "R12 reset releases",
        {dbg_clk_oe, dbg_dat_oe, entry_done}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!dbg_clk_oe && !entry_done, "R12 stays idle", {dbg_clk_oe, entry_done}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_sequence(-1, "plain");
        t_sequence(1, "R9 ignore");
        t_restart_and_abort();
      end
      begin
        repeat (180000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule